// File: doc/BRIEF.md
# Command Semaphore Snapshot Register

This block sits behind a byte-addressed register window and lets a bus controller take a coherent two-byte sample of a free-running 16-bit value. The local logic presents a new sample on every cycle in which its valid strobe is high. The controller does not read the value directly. It first writes any non-zero code into a one-byte command register. The block then copies the next valid sample into a 16-bit result register and clears the command byte in that same clock edge. When the controller sees the command byte read back as zero, it knows the result is fresh. It can then fetch the high and low result bytes without any risk of pairing bytes from two different samples.

The roles on the command byte are split. The bus side can only make it non-zero, and only the capture logic can return it to zero. Two further bytes keep working without the semaphore. A read-only status byte mirrors a live input on every read. A control byte is written by the bus and drives a block output continuously. Reads return data through a registered port, one cycle after the request.

Top module: `cmd_snapshot_regs`

## Requirements
- R1: After reset, the command byte, both result bytes and the control byte read as 0x00, `ctrl_o` is 0x00 and `bus_rvalid_o` is low.
- R2: A bus write of 0x00 to the command byte (offset 0) has no effect, whether the command byte is zero or pending, and it starts no capture.
- R3: A bus write of a non-zero value to offset 0 stores that value, and the value reads back unchanged until a capture clears it.
- R4: While the command byte is zero, sample strobes leave the result register unchanged.
- R5: The first clock edge at which the command byte already holds a non-zero value and the strobe is high loads the sample into the result register and clears the command byte at that same edge. A strobe in the cycle of the set write itself is not used.
- R6: The result high byte (sample bits 15:8) is at offset 1 and the low byte (bits 7:0) is at offset 2. Both come from the same captured sample.
- R7: A non-zero write to offset 0 while a capture is pending replaces the stored code, and the command stays pending.
- R8: Bus writes to the result offsets (1, 2) and to the status offset (3) are ignored.
- R9: Offset 3 returns `live_stat_i` as sampled at each read, with no dependence on the semaphore. Offset 4 is a read/write control byte whose value drives `ctrl_o` from the edge after the write.
- R10: When a non-zero command write coincides with a capture edge, the capture still happens and the command byte takes the newly written value.
- R11: Read data and `bus_rvalid_o` appear one cycle after `bus_re_i`. Offsets 5 to 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 16 | Free-running sample value |
| smp_vld_i | input | 1 | Sample valid strobe |
| live_stat_i | input | 8 | Live status byte exposed at offset 3 |
| ctrl_o | output | 8 | Control byte written at offset 4 |
| bus_we_i | input | 1 | Bus byte write enable |
| bus_waddr_i | input | 3 | Bus write offset |
| bus_wdata_i | input | 8 | Bus write data |
| bus_re_i | input | 1 | Bus byte read request |
| bus_raddr_i | input | 3 | Bus read offset |
| bus_rdata_o | output | 8 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after request |

## Verification
The critical overlap is a capture edge and a bus set write landing on the same clock. The clear comes from the local side and the set comes from the bus, and the set must win while the result still loads. The bench first arms the command, then drives a new non-zero code together with a sample strobe in one cycle. It checks that the result holds that sample and that the command reads back as the new code. A second overlap, a set write together with a strobe while the command is still zero, must not capture. The bench judges it by the unchanged result and a later capture of the next strobe.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [2:0] {
    SRC_CMD  = 3'd0,
    SRC_HI   = 3'd1,
    SRC_LO   = 3'd2,
    SRC_STAT = 3'd3,
    SRC_CTRL = 3'd4,
    SRC_NONE = 3'd5
  } rd_src_e;
endpackage

// File: rtl/sem_cmd_reg.sv
module sem_cmd_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              local_clr,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              busy_o
);
  logic [BYTE_W-1:0] cmd_q;
  logic              set_req;

  // bus may only raise the byte: zero writes are filtered here
  assign set_req = bus_we && (bus_wdata != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (set_req) begin
      cmd_q <= bus_wdata;
    end else if (local_clr) begin
      cmd_q <= '0;
    end
  end

  assign cmd_o  = cmd_q;
  assign busy_o = (cmd_q != '0);

  assert_zero_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wdata == '0 && !local_clr) |=> $stable(cmd_q));

  assert_only_bus_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == '0 && !(bus_we && bus_wdata != '0)) |=> (cmd_q == '0));

  assert_only_local_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != '0 && !local_clr) |=> (cmd_q != '0));

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wdata != '0 && local_clr) |=> (cmd_q == $past(bus_wdata)));
endmodule

// File: rtl/snap_result_reg.sv
module snap_result_reg #(
  parameter int BYTE_W = 8,
  localparam int RES_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed_i,
  input  logic             smp_vld_i,
  input  logic [RES_W-1:0] smp_i,
  output logic [RES_W-1:0] res_o,
  output logic             cap_o
);
  logic [RES_W-1:0] res_q;

  // both bytes load in one edge so the pair always belongs to one sample
  assign cap_o = armed_i && smp_vld_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (cap_o) begin
      res_q <= smp_i;
    end
  end

  assign res_o = res_q;

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !armed_i |=> $stable(res_q));

  assert_capture_whole_R6: assert property (@(posedge clk) disable iff (rst)
    (armed_i && smp_vld_i) |=> (res_q == $past(smp_i)));
endmodule

// File: rtl/snap_rd_port.sv
module snap_rd_port
  import snap_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int BYTE_W   = 8,
  parameter int OFS_CMD  = 0,
  parameter int OFS_HI   = 1,
  parameter int OFS_LO   = 2,
  parameter int OFS_STAT = 3,
  parameter int OFS_CTRL = 4,
  localparam int RES_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [BYTE_W-1:0] stat_i,
  input  logic [BYTE_W-1:0] ctrl_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rvalid_o
);
  rd_src_e           src;
  logic [BYTE_W-1:0] mux_d;
  logic [BYTE_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    if      (rd_addr == ADDR_W'(OFS_CMD))  src = SRC_CMD;
    else if (rd_addr == ADDR_W'(OFS_HI))   src = SRC_HI;
    else if (rd_addr == ADDR_W'(OFS_LO))   src = SRC_LO;
    else if (rd_addr == ADDR_W'(OFS_STAT)) src = SRC_STAT;
    else if (rd_addr == ADDR_W'(OFS_CTRL)) src = SRC_CTRL;
    else                                   src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_CMD:  mux_d = cmd_i;
      SRC_HI:   mux_d = res_i[RES_W-1:BYTE_W];
      SRC_LO:   mux_d = res_i[BYTE_W-1:0];
      SRC_STAT: mux_d = stat_i;
      SRC_CTRL: mux_d = ctrl_i;
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= mux_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid_q);

  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid_q);
endmodule

// File: rtl/cmd_snapshot_regs.sv
module cmd_snapshot_regs #(
  parameter int ADDR_W   = 3,
  parameter int BYTE_W   = 8,
  parameter int OFS_CMD  = 0,
  parameter int OFS_HI   = 1,
  parameter int OFS_LO   = 2,
  parameter int OFS_STAT = 3,
  parameter int OFS_CTRL = 4,
  localparam int RES_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RES_W-1:0]  smp_i,
  input  logic              smp_vld_i,
  input  logic [BYTE_W-1:0] live_stat_i,
  output logic [BYTE_W-1:0] ctrl_o,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_waddr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_raddr_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o
);
  logic              we_cmd;
  logic              we_ctrl;
  logic [BYTE_W-1:0] cmd;
  logic              busy;
  logic              cap;
  logic [RES_W-1:0]  res;
  logic [BYTE_W-1:0] ctrl_q;

  // write decode: result and status offsets have no write path at all
  assign we_cmd  = bus_we_i && (bus_waddr_i == ADDR_W'(OFS_CMD));
  assign we_ctrl = bus_we_i && (bus_waddr_i == ADDR_W'(OFS_CTRL));

  sem_cmd_reg #(.BYTE_W(BYTE_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (we_cmd),
    .bus_wdata (bus_wdata_i),
    .local_clr (cap),
    .cmd_o     (cmd),
    .busy_o    (busy)
  );

  snap_result_reg #(.BYTE_W(BYTE_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .armed_i   (busy),
    .smp_vld_i (smp_vld_i),
    .smp_i     (smp_i),
    .res_o     (res),
    .cap_o     (cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we_ctrl) begin
      ctrl_q <= bus_wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;

  snap_rd_port #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .OFS_CMD  (OFS_CMD),
    .OFS_HI   (OFS_HI),
    .OFS_LO   (OFS_LO),
    .OFS_STAT (OFS_STAT),
    .OFS_CTRL (OFS_CTRL)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_re_i),
    .rd_addr  (bus_raddr_i),
    .cmd_i    (cmd),
    .res_i    (res),
    .stat_i   (live_stat_i),
    .ctrl_i   (ctrl_q),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );

  assert_clear_with_load_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && smp_vld_i && !(we_cmd && bus_wdata_i != '0)) |=> (cmd == '0 && res == $past(smp_i)));

  assert_ctrl_follows_write_R9: assert property (@(posedge clk) disable iff (rst)
    we_ctrl |=> (ctrl_o == $past(bus_wdata_i)));

  assert_result_not_bus_written_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && smp_vld_i) |=> $stable(res));
endmodule

// File: tb/sim_cmd_snapshot_regs.sv
module sim_cmd_snapshot_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic [7:0]  live_stat_i = '0;
  logic [7:0]  ctrl_o;
  logic        bus_we_i = 1'b0;
  logic [2:0]  bus_waddr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic        bus_re_i = 1'b0;
  logic [2:0]  bus_raddr_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        bus_rvalid_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cmd_snapshot_regs u0 (
    .clk(clk), .rst(rst), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .live_stat_i(live_stat_i), .ctrl_o(ctrl_o),
    .bus_we_i(bus_we_i), .bus_waddr_i(bus_waddr_i), .bus_wdata_i(bus_wdata_i),
    .bus_re_i(bus_re_i), .bus_raddr_i(bus_raddr_i),
    .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (!rst && bus_rvalid_o) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected rvalid", 16'(bus_rvalid_o), 16'd0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 16'(bus_rdata_o), 16'(e));
      end
    end
  end

  task automatic rd(logic [2:0] a, logic [7:0] e, string t);
    @(negedge clk);
    bus_re_i = 1'b1; bus_raddr_i = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re_i = 1'b0;
  endtask

  // one cycle with optional write and optional strobe in the same cycle
  task automatic cyc(logic we, logic [2:0] a, logic [7:0] d, logic v, logic [15:0] s);
    @(negedge clk);
    bus_we_i = we; bus_waddr_i = a; bus_wdata_i = d;
    smp_vld_i = v; smp_i = s;
    @(negedge clk);
    bus_we_i = 1'b0; smp_vld_i = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", wd);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rvalid idle", 16'(bus_rvalid_o), 16'd0);
    check("R1 ctrl_o", 16'(ctrl_o), 16'd0);
    rd(3'd0, 8'h00, "R1 cmd");
    rd(3'd1, 8'h00, "R1 res hi");
    rd(3'd2, 8'h00, "R1 res lo");
    rd(3'd4, 8'h00, "R1 ctrl");
    // R4 strobes without command
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 16'h1234);
    rd(3'd1, 8'h00, "R4 hi unchanged");
    rd(3'd2, 8'h00, "R4 lo unchanged");
    // R2 zero write while idle
    cyc(1'b1, 3'd0, 8'h00, 1'b0, 16'h0);
    rd(3'd0, 8'h00, "R2 zero write idle");
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 16'h4321);
    rd(3'd2, 8'h00, "R2 no capture after zero write");
    // R3 set and hold
    cyc(1'b1, 3'd0, 8'h5A, 1'b0, 16'h0);
    rd(3'd0, 8'h5A, "R3 set readback");
    rd(3'd0, 8'h5A, "R3 set holds");
    // R2 zero write while pending, R7 overwrite
    cyc(1'b1, 3'd0, 8'h00, 1'b0, 16'h0);
    rd(3'd0, 8'h5A, "R2 zero write pending");
    cyc(1'b1, 3'd0, 8'h33, 1'b0, 16'h0);
    rd(3'd0, 8'h33, "R7 overwrite pending");
    // R5/R6 capture
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 16'hBEEF);
    rd(3'd0, 8'h00, "R5 cmd cleared");
    rd(3'd1, 8'hBE, "R6 hi byte");
    rd(3'd2, 8'hEF, "R6 lo byte");
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 16'h0102);
    rd(3'd1, 8'hBE, "R4 hi after clear");
    rd(3'd2, 8'hEF, "R4 lo after clear");
    // R8 read-only offsets
    cyc(1'b1, 3'd1, 8'h77, 1'b0, 16'h0);
    cyc(1'b1, 3'd2, 8'h66, 1'b0, 16'h0);
    rd(3'd1, 8'hBE, "R8 hi write ignored");
    rd(3'd2, 8'hEF, "R8 lo write ignored");
    live_stat_i = 8'hA5;
    cyc(1'b1, 3'd3, 8'h11, 1'b0, 16'h0);
    rd(3'd3, 8'hA5, "R8 status write ignored");
    // R9 live status and control
    live_stat_i = 8'h3C;
    rd(3'd3, 8'h3C, "R9 status live");
    cyc(1'b1, 3'd4, 8'h81, 1'b0, 16'h0);
    check("R9 ctrl_o", 16'(ctrl_o), 16'h0081);
    rd(3'd4, 8'h81, "R9 ctrl readback");
    // R10 set write together with capture edge
    cyc(1'b1, 3'd0, 8'h22, 1'b0, 16'h0);
    cyc(1'b1, 3'd0, 8'h11, 1'b1, 16'h4455);
    rd(3'd0, 8'h11, "R10 set wins");
    rd(3'd1, 8'h44, "R10 hi captured");
    rd(3'd2, 8'h55, "R10 lo captured");
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 16'h6677);
    rd(3'd0, 8'h00, "R5 second capture clears");
    rd(3'd2, 8'h77, "R5 second capture lo");
    // R5 strobe in cycle of set write is not used
    cyc(1'b1, 3'd0, 8'h09, 1'b1, 16'hAAAA);
    rd(3'd0, 8'h09, "R5 set cycle strobe skipped");
    rd(3'd1, 8'h66, "R5 result unchanged");
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 16'h1357);
    rd(3'd1, 8'h13, "R5 next strobe hi");
    rd(3'd2, 8'h57, "R5 next strobe lo");
    // R11 unmapped and latency
    rd(3'd6, 8'h00, "R11 unmapped");
    @(negedge clk);
    check("R11 rvalid drops", 16'(bus_rvalid_o), 16'd0);
    repeat (2) @(negedge clk);
    check("R11 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule